// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single timer channel built around a 32-bit down-counter. A free-running prescaler supplies five tick rates, and a 3-bit select field in the control word chooses one of them. A run bit gates counting. Each selected tick lowers the count by one. When a tick arrives with the count at zero, the counter takes the value of a 32-bit reload register in place of wrapping to all ones. In the same cycle a sticky wrap flag is raised, and counting goes on from the reloaded value.

Software sees the block through a 16-bit register bus. The bus decodes five word addresses: the counter halves, the reload register halves and the control word. The 32-bit counter is moving, so a read of its lower half also copies the whole count into a snapshot buffer. The later read of the upper half returns that copy, and both halves therefore come from one instant. Counter writes use the same pairing. The upper half is held in a staging register, and the lower-half write loads all 32 bits in one cycle.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter reads 0xFFFFFFFF, the reload register reads 0xFFFFFFFF, and the control word (address 4) reads 0x0000.
- R2: While the run bit (control bit 3) is 1, select codes 0, 1, 2, 3 and 4 (control bits 2:0) give one decrement every 4, 16, 64, 256 and 1024 clocks respectively.
- R3: With the run bit 0, or with a reserved select code 5, 6 or 7, the counter holds its value.
- R4: A tick taken at a count of zero loads the reload register value into the counter, and later ticks count down from that value.
- R5: A tick taken at a count of zero sets the wrap flag (control bit 8), and the flag stays set through later cycles.
- R6: A control write with bit 8 equal to 0 clears the wrap flag, and a write with bit 8 equal to 1 leaves it unchanged. If a wrap occurs in the same cycle as a clearing write, the flag ends up set.
- R7: A read of address 0 returns counter bits 15:0 and copies the whole counter into the snapshot buffer. A read of address 1 returns snapshot bits 31:16, even if the counter has changed since the copy was taken.
- R8: A write to address 1 only stages the upper half and leaves the counter unchanged. A write to address 0 loads the counter with the staged upper half and the written lower half together.
- R9: The reload register's lower half (address 2) and upper half (address 3) can each be written and read back independently.
- R10: The control word reads back the select code in bits 2:0, the run bit in bit 3 and the wrap flag in bit 8, with all other bits reading 0. The wrap flag is also driven on the `wrapFlag` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 3 | Word address: 0 counter low, 1 counter high, 2 reload low, 3 reload high, 4 control |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data, valid in the cycle busSel is high |
| wrapFlag | output | 1 | Sticky wrap flag |

## Verification
A wrong count or a missed reload appears at the counter ports on the next paired read. The bench checks the exact decrement over a whole number of prescaler periods, so one extra or missing tick is caught after at most one window. A stale or shared snapshot shows up on the first upper-half read that follows a counter change. A faulty flag priority shows up on the control read one cycle after a wrap is lined up with a clearing write. The bench finds the prescaler phase by watching the count change, and then places that write in the exact tick cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W      = 32;
  localparam int BUS_W      = 16;
  localparam int ADDR_W     = 3;
  localparam int SEL_W      = 3;
  localparam int NUM_RATIOS = 5;
  localparam int RATIO_STEP = 2;
  localparam int PRE_W      = RATIO_STEP * NUM_RATIOS;
  localparam int RUN_BIT    = 3;
  localparam int FLAG_BIT   = 8;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CNT_LO   = 3'd0,
    ADR_CNT_HI   = 3'd1,
    ADR_RLD_LO   = 3'd2,
    ADR_RLD_HI   = 3'd3,
    ADR_CTRL     = 3'd4
  } regAddr_e;

  typedef struct packed {
    logic tick;
    logic cntStageHi;
    logic cntCommit;
    logic rldWrLo;
    logic rldWrHi;
    logic snapTake;
  } dpStrobes_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [BUS_W-1:0] wData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] rldQ,
  output logic [CNT_W-1:0] snapQ,
  output logic             underflow
);
  localparam int HALF = CNT_W / 2;

  logic [HALF-1:0] stageHi;

  assign underflow = strobes.tick && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '1;
      rldQ    <= '1;
      snapQ   <= '0;
      stageHi <= '0;
    end else begin
      if (strobes.cntStageHi) stageHi <= wData[HALF-1:0];
      if (strobes.cntCommit)  cntQ <= {stageHi, wData[HALF-1:0]};
      else if (strobes.tick)  cntQ <= underflow ? rldQ : cntQ - 1'b1;
      if (strobes.rldWrLo)    rldQ[HALF-1:0] <= wData[HALF-1:0];
      if (strobes.rldWrHi)    rldQ[CNT_W-1:HALF] <= wData[HALF-1:0];
      if (strobes.snapTake)   snapQ <= cntQ;
    end
  end

  // R2: a tick at a nonzero count lowers it by exactly one
  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.cntCommit && cntQ != '0) |=> cntQ == $past(cntQ) - 1'b1);
  // R4: a tick at zero takes the reload value
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.cntCommit && cntQ == '0) |=> cntQ == $past(rldQ));
  // R3: without tick or commit the count holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && !strobes.cntCommit) |=> $stable(cntQ));
  // R7: the snapshot equals the count at the capturing read
  assert_snapshot_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.snapTake |=> snapQ == $past(cntQ));
  // R8: a commit loads staged upper half with written lower half
  assert_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntCommit |=> cntQ == {$past(stageHi), $past(wData[HALF-1:0])});
endmodule

// File: rtl/timer_control.sv
module timer_control
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWData,
  input  logic              underflow,
  output dpStrobes_t        strobes,
  output logic [BUS_W-1:0]  ctrlWord,
  output logic              flagQ
);
  localparam int NUM_CODES = 1 << SEL_W;

  logic [PRE_W-1:0]     preCnt;
  logic [SEL_W-1:0]     selQ;
  logic                 runQ;
  logic [NUM_CODES-1:0] tickByCode;
  logic                 wrEn, rdEn, ctrlWr, clrReq;
  regAddr_e             addr;

  assign addr   = regAddr_e'(busAddr);
  assign wrEn   = busSel && busWr;
  assign rdEn   = busSel && !busWr;
  assign ctrlWr = wrEn && (addr == ADR_CTRL);
  assign clrReq = ctrlWr && !busWData[FLAG_BIT];

  // one tick source per select code; reserved codes never tick
  for (genvar c = 0; c < NUM_CODES; c++) begin : gTick
    if (c < NUM_RATIOS) begin : gRatio
      assign tickByCode[c] = &preCnt[RATIO_STEP*(c+1)-1:0];
    end else begin : gReserved
      assign tickByCode[c] = 1'b0;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.tick       = runQ && tickByCode[selQ];
    strobes.cntStageHi = wrEn && (addr == ADR_CNT_HI);
    strobes.cntCommit  = wrEn && (addr == ADR_CNT_LO);
    strobes.rldWrLo    = wrEn && (addr == ADR_RLD_LO);
    strobes.rldWrHi    = wrEn && (addr == ADR_RLD_HI);
    strobes.snapTake   = rdEn && (addr == ADR_CNT_LO);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      selQ   <= '0;
      runQ   <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (ctrlWr) begin
        selQ <= busWData[SEL_W-1:0];
        runQ <= busWData[RUN_BIT];
      end
      if (underflow)   flagQ <= 1'b1;
      else if (clrReq) flagQ <= 1'b0;
    end
  end

  always_comb begin
    ctrlWord            = '0;
    ctrlWord[SEL_W-1:0] = selQ;
    ctrlWord[RUN_BIT]   = runQ;
    ctrlWord[FLAG_BIT]  = flagQ;
  end

  // R5: a wrap always leaves the flag set
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> flagQ);
  // R6: only a clearing control write can drop the flag
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clrReq) |=> flagQ);
  // R3: stopped or reserved settings give no tick
  assert_no_tick_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ || selQ >= SEL_W'(NUM_RATIOS)) |-> !strobes.tick);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWData,
  output logic [BUS_W-1:0]  busRData,
  output logic              wrapFlag
);
  dpStrobes_t       strobes;
  logic [CNT_W-1:0] cntQ, rldQ, snapQ;
  logic [BUS_W-1:0] ctrlWord;
  logic             underflow;

  timer_control uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWData(busWData), .underflow(underflow),
    .strobes(strobes), .ctrlWord(ctrlWord), .flagQ(wrapFlag)
  );

  timer_datapath uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wData(busWData),
    .cntQ(cntQ), .rldQ(rldQ), .snapQ(snapQ), .underflow(underflow)
  );

  always_comb begin
    unique case (regAddr_e'(busAddr))
      ADR_CNT_LO: busRData = cntQ[BUS_W-1:0];
      ADR_CNT_HI: busRData = snapQ[CNT_W-1:BUS_W];
      ADR_RLD_LO: busRData = rldQ[BUS_W-1:0];
      ADR_RLD_HI: busRData = rldQ[CNT_W-1:BUS_W];
      ADR_CTRL:   busRData = ctrlWord;
      default:    busRData = '0;
    endcase
  end
endmodule

// File: tb/reload_timer_test.sv
`timescale 1ns/1ps
module reload_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0, chkEn = 1'b0, done = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic        wrapFlag;
  int          nCmp = 0, nBad = 0;
  logic [15:0] expQ[$];
  string       reqQ[$];

  always #2 clk = ~clk;

  reload_timer uut (.clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData), .wrapFlag(wrapFlag));

  // monitor: pops expected read data and compares mid-cycle
  always @(negedge clk) begin
    #1;
    if (chkEn && expQ.size() > 0) begin
      logic [15:0] e;
      string r;
      e = expQ.pop_front();
      r = reqQ.pop_front();
      nCmp++;
      if (busRData !== e) begin
        nBad++;
        $display("FAIL %s: addr %0d read %h expected %h", r, busAddr, busRData, e);
      end
    end
  end

  task automatic checkVal(input string r, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWData = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic readCheck(input logic [2:0] a, input logic [15:0] e, input string r);
    @(negedge clk);
    expQ.push_back(e); reqQ.push_back(r);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; chkEn = 1'b1;
    @(posedge clk); #1;
    busSel = 1'b0; chkEn = 1'b0;
  endtask

  task automatic readRaw(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 v = busRData;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic readWord(output logic [31:0] v);
    logic [15:0] lo, hi;
    readRaw(3'd0, lo);
    readRaw(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // reads the count, waits exactly n*k clocks between captures, checks the drop
  task automatic measure(input int n, input int k, input logic [31:0] expDrop, input string r);
    logic [31:0] v0, v1;
    readWord(v0);
    idle(n * k - 2);
    readWord(v1);
    checkVal(r, v0 - v1, expDrop);
  endtask

  task automatic setCount(input logic [31:0] v);
    busWrite(3'd1, v[31:16]);
    busWrite(3'd0, v[15:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev, cur;
    logic        seen;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    readCheck(3'd0, 16'hFFFF, "R1");
    readCheck(3'd1, 16'hFFFF, "R1");
    readCheck(3'd2, 16'hFFFF, "R1");
    readCheck(3'd3, 16'hFFFF, "R1");
    readCheck(3'd4, 16'h0000, "R1");

    // R9 reload halves independent
    busWrite(3'd3, 16'h1234);
    readCheck(3'd2, 16'hFFFF, "R9");
    readCheck(3'd3, 16'h1234, "R9");
    busWrite(3'd2, 16'h5678);
    readCheck(3'd2, 16'h5678, "R9");
    readCheck(3'd3, 16'h1234, "R9");

    // R8 staged upper half
    busWrite(3'd1, 16'hABCD);
    readCheck(3'd0, 16'hFFFF, "R8");
    readCheck(3'd1, 16'hFFFF, "R8");
    busWrite(3'd0, 16'h0123);
    readCheck(3'd0, 16'h0123, "R8");
    readCheck(3'd1, 16'hABCD, "R8");

    // R7 upper read returns the snapshot, not the live count
    setCount(32'h0001_0000);
    readCheck(3'd0, 16'h0000, "R7");
    setCount(32'h0000_FFFF);
    readCheck(3'd1, 16'h0001, "R7");
    readCheck(3'd0, 16'hFFFF, "R7");
    readCheck(3'd1, 16'h0000, "R7");

    // R10 control layout
    busWrite(3'd4, 16'hFEF5);
    readCheck(3'd4, 16'h0005, "R10");
    busWrite(3'd4, 16'h0000);

    // R4 R5 wrap: count 2 for exactly 20 clocks at /4 = 5 ticks
    setCount(32'h0000_0002);
    busWrite(3'd4, 16'h0008);
    idle(19);
    busWrite(3'd4, 16'h0100);
    readCheck(3'd0, 16'h5676, "R4");
    readCheck(3'd1, 16'h1234, "R4");
    readCheck(3'd4, 16'h0100, "R5");
    checkVal("R10", {31'd0, wrapFlag}, 32'd1);
    idle(10);
    readCheck(3'd4, 16'h0100, "R5");

    // R6 wrap beats a same-cycle clear: find prescaler phase first
    setCount(32'h0000_1000);
    busWrite(3'd4, 16'h0108);
    readRaw(3'd0, prev);
    seen = 1'b0;
    for (int i = 0; i < 12 && !seen; i++) begin
      readRaw(3'd0, cur);
      if (cur != prev) seen = 1'b1;
      prev = cur;
    end
    checkVal("R2", {31'd0, seen}, 32'd1);
    // last read edge t; tick edges at t+3, t+7
    busWrite(3'd1, 16'h0000);
    busWrite(3'd0, 16'h0000);
    busWrite(3'd4, 16'h0008);
    readCheck(3'd4, 16'h0108, "R6");
    busWrite(3'd4, 16'h0008);
    readCheck(3'd4, 16'h0008, "R6");
    readCheck(3'd0, 16'h5678, "R4");
    readCheck(3'd1, 16'h1234, "R4");
    busWrite(3'd4, 16'h0100);
    readCheck(3'd4, 16'h0000, "R6");

    // R2 every ratio
    setCount(32'h0F00_0000);
    busWrite(3'd4, 16'h0008); measure(4, 2, 32'd2, "R2 div4");
    busWrite(3'd4, 16'h0009); measure(16, 2, 32'd2, "R2 div16");
    busWrite(3'd4, 16'h000A); measure(64, 2, 32'd2, "R2 div64");
    busWrite(3'd4, 16'h000B); measure(256, 2, 32'd2, "R2 div256");
    busWrite(3'd4, 16'h000C); measure(1024, 2, 32'd2, "R2 div1024");

    // R3 stopped and reserved
    busWrite(3'd4, 16'h000D); measure(16, 4, 32'd0, "R3 code5");
    busWrite(3'd4, 16'h000F); measure(16, 4, 32'd0, "R3 code7");
    busWrite(3'd4, 16'h0000); measure(16, 4, 32'd0, "R3 run0");

    idle(2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule